// File: doc/BRIEF.md
# Coprocessor Bus Slave with Read Hold-Off

This block connects an iterative shift-and-add multiplier core to a simple read/write system bus. It occupies a window of four consecutive word addresses starting at a parameterised base that is aligned to four words. Three of the slots map to the core's data registers: the multiplicand, the accumulator and the multiplier. The fourth slot is a control slot. Writing to the control slot launches an operation. Reading it returns the core's busy flag, so software can poll.

Software can also skip polling. While the core is busy, a read of a register that still holds a partial result raises a wait line. The bus master stalls on that line until the core goes idle, and the read then completes with the final value. The block does not drive storage itself. It produces load strobes with the write data, a one-cycle start pulse and a one-hot read-select vector for the core, and it builds the read data from the register values the core presents.

Top module: `coproc_bus_slave`

## Requirements
- R1: With the core idle, a read strobe at base+0, base+1 or base+2 returns the multiplicand, accumulator or multiplier value on `bus_rdata` in the same cycle. `rd_sel` is one-hot with bit 0 for the multiplicand, bit 1 for the accumulator, bit 2 for the multiplier and bit 3 for the control slot.
- R2: With the core idle, a write strobe at base+0, base+1 or base+2 raises `ld_icand`, `ld_acc` or `ld_ier` respectively in that same cycle. `ld_data` equals `bus_wdata`.
- R3: A write to base+3 while the core is idle raises `start_pulse` in the following cycle for exactly one cycle. This holds whatever the data value is, and it also holds if the write strobe stays high for several cycles.
- R4: A read at base+3 returns the busy flag in bit 0 with all other bits zero. It never raises `bus_wait`.
- R5: A read at base+1 while `core_run` is 1 raises `bus_wait` and returns zero data. In the cycle `core_run` returns to 0, `bus_wait` falls and the accumulator value is returned.
- R6: A read at base+2 while `core_run` is 1 behaves like R5 (when HOLD_IER is 1, the default). A read at base+0 while busy is never held.
- R7: While `core_run` is 1, writes at base+0 to base+2 raise no load strobe, and a write at base+3 raises no start pulse.
- R8: An address outside the four-word window raises no load strobe, no start pulse, no read select and no wait, and the read data is zero.
- R9: After reset `start_pulse` is 0, and with no strobes every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | DW | Read data, zero when no valid read |
| bus_wait | output | 1 | Stall request to the master |
| core_run | input | 1 | Busy flag from the core sequencer |
| core_icand | input | DW | Multiplicand register value |
| core_acc | input | DW | Accumulator register value |
| core_ier | input | DW | Multiplier register value |
| ld_icand | output | 1 | Load multiplicand |
| ld_acc | output | 1 | Load accumulator |
| ld_ier | output | 1 | Load multiplier |
| ld_data | output | DW | Data for the load strobes |
| start_pulse | output | 1 | One-cycle operation start |
| rd_sel | output | 4 | One-hot read select to the core |

## Verification
The hardest case is the release of a held read. The read strobe must stay on a result slot while the busy flag is high, and the flag must then drop at a moment the bench chooses. The bench models the busy flag itself. It first holds an accumulator read, and then a multiplier read, across several busy cycles, checking for a raised wait and zero data in each of those cycles. It then clears the flag with the strobe still held and checks that wait falls and the correct data appears in that same cycle. A write strobe held for several cycles on the control slot covers the single-pulse edge case.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
   localparam int unsigned NUM_SLOTS = 4;

   typedef enum logic [1:0] {
      SLOT_ICAND = 2'd0,
      SLOT_ACC   = 2'd1,
      SLOT_IER   = 2'd2,
      SLOT_CTRL  = 2'd3
   } cbw_slot_e;
endpackage

// File: rtl/cbw_decode.sv
module cbw_decode #(
   parameter int unsigned AW   = 16,
   parameter int unsigned BASE = 32'h40
) (
   input  logic [AW-1:0]                  addr,
   output logic                           hit,
   output logic [cbw_pkg::NUM_SLOTS-1:0]  slot_oh
);
   localparam logic [AW-1:0] BASE_V = AW'(BASE);

   generate
      if (AW < 3) begin : g_bad_aw
         $error("cbw_decode: AW must be at least 3");
      end
      if ((BASE % 4) != 0) begin : g_bad_base
         $error("cbw_decode: BASE must be aligned to four words");
      end
   endgenerate

   assign hit = (addr[AW-1:2] == BASE_V[AW-1:2]);

   for (genvar i = 0; i < cbw_pkg::NUM_SLOTS; i++) begin : g_slot
      assign slot_oh[i] = hit && (addr[1:0] == 2'(i));
   end
endmodule

// File: rtl/cbw_waitgen.sv
module cbw_waitgen #(
   parameter bit HOLD_IER = 1'b1
) (
   input  logic                          rd,
   input  logic [cbw_pkg::NUM_SLOTS-1:0] slot_oh,
   input  logic                          run,
   output logic                          hold
);
   import cbw_pkg::*;
   logic guarded;

   generate
      if (HOLD_IER) begin : g_hold_both
         assign guarded = slot_oh[SLOT_ACC] | slot_oh[SLOT_IER];
      end else begin : g_hold_acc
         assign guarded = slot_oh[SLOT_ACC];
      end
   endgenerate

   assign hold = rd && run && guarded;
endmodule

// File: rtl/cbw_rdmux.sv
module cbw_rdmux #(
   parameter int unsigned DW = 16
) (
   input  logic [cbw_pkg::NUM_SLOTS-1:0] sel,
   input  logic [DW-1:0]                 icand,
   input  logic [DW-1:0]                 acc,
   input  logic [DW-1:0]                 ier,
   input  logic                          run,
   output logic [DW-1:0]                 rdata
);
   import cbw_pkg::*;
   logic [DW-1:0] src [NUM_SLOTS];

   assign src[SLOT_ICAND] = icand;
   assign src[SLOT_ACC]   = acc;
   assign src[SLOT_IER]   = ier;
   assign src[SLOT_CTRL]  = DW'(run);

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         rdata = rdata | (src[i] & {DW{sel[i]}});
      end
   end
endmodule

// File: rtl/coproc_bus_slave.sv
module coproc_bus_slave #(
   parameter int unsigned AW       = 16,
   parameter int unsigned DW       = 16,
   parameter int unsigned BASE     = 32'h40,
   parameter bit          HOLD_IER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_rd,
   input  logic          bus_wr,
   output logic [DW-1:0] bus_rdata,
   output logic          bus_wait,
   input  logic          core_run,
   input  logic [DW-1:0] core_icand,
   input  logic [DW-1:0] core_acc,
   input  logic [DW-1:0] core_ier,
   output logic          ld_icand,
   output logic          ld_acc,
   output logic          ld_ier,
   output logic [DW-1:0] ld_data,
   output logic          start_pulse,
   output logic [3:0]    rd_sel
);
   import cbw_pkg::*;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("coproc_bus_slave: DW must be positive");
      end
   endgenerate

   logic                 hit;
   logic [NUM_SLOTS-1:0] slot_oh;
   logic                 hold;
   logic                 wr_ok;
   logic                 ctrl_wr;
   logic                 ctrl_wr_q;

   cbw_decode #(.AW(AW), .BASE(BASE)) u_decode (
      .addr    (bus_addr),
      .hit     (hit),
      .slot_oh (slot_oh)
   );

   cbw_waitgen #(.HOLD_IER(HOLD_IER)) u_waitgen (
      .rd      (bus_rd),
      .slot_oh (slot_oh),
      .run     (core_run),
      .hold    (hold)
   );

   assign bus_wait = hold;
   assign rd_sel   = (bus_rd && !hold) ? slot_oh : '0;

   cbw_rdmux #(.DW(DW)) u_rdmux (
      .sel   (rd_sel),
      .icand (core_icand),
      .acc   (core_acc),
      .ier   (core_ier),
      .run   (core_run),
      .rdata (bus_rdata)
   );

   assign wr_ok    = bus_wr && !core_run;
   assign ld_icand = wr_ok && slot_oh[SLOT_ICAND];
   assign ld_acc   = wr_ok && slot_oh[SLOT_ACC];
   assign ld_ier   = wr_ok && slot_oh[SLOT_IER];
   assign ld_data  = bus_wdata;
   assign ctrl_wr  = bus_wr && slot_oh[SLOT_CTRL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_wr_q   <= 1'b0;
         start_pulse <= 1'b0;
      end else begin
         ctrl_wr_q   <= ctrl_wr;
         start_pulse <= ctrl_wr && !ctrl_wr_q && !core_run;
      end
   end

   assert_wait_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wait |-> (core_run && bus_rd && hit));
   assert_wait_zero_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wait |-> (bus_rdata == '0));
   assert_no_load_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      core_run |-> !(ld_icand || ld_acc || ld_ier));
   assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);
   assert_rsel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_sel));
   assert_outside_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (rd_sel == 4'b0 && !bus_wait && !ld_icand && !ld_acc && !ld_ier));
   assert_status_no_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && slot_oh[SLOT_CTRL]) |-> !bus_wait);
endmodule

// File: tb/coproc_bus_slave_tb.sv
module coproc_bus_slave_tb;
   localparam int unsigned AW = 16;
   localparam int unsigned DW = 16;
   localparam logic [AW-1:0] B = 16'h0040;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic bus_rd = 1'b0, bus_wr = 1'b0, core_run = 1'b0;
   logic [DW-1:0] core_icand = 16'h1234, core_acc = 16'hBEEF, core_ier = 16'h0F0F;
   logic [DW-1:0] bus_rdata, ld_data;
   logic bus_wait, ld_icand, ld_acc, ld_ier, start_pulse;
   logic [3:0] rd_sel;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   coproc_bus_slave #(.AW(AW), .DW(DW), .BASE(32'h40)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
      .core_run(core_run), .core_icand(core_icand), .core_acc(core_acc),
      .core_ier(core_ier), .ld_icand(ld_icand), .ld_acc(ld_acc), .ld_ier(ld_ier),
      .ld_data(ld_data), .start_pulse(start_pulse), .rd_sel(rd_sel)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic idle_bus();
      bus_rd = 1'b0;
      bus_wr = 1'b0;
   endtask

   task automatic t_reset();
      settle();
      chk(start_pulse, 0, "R9 start in reset");
      rst_n = 1'b1;
      step();
      settle();
      chk({ld_icand, ld_acc, ld_ier, start_pulse, bus_wait}, 0, "R9 idle strobes");
      chk(rd_sel, 0, "R9 idle rd_sel");
      chk(bus_rdata, 0, "R9 idle rdata");
   endtask

   task automatic t_reads_idle();
      bus_rd = 1'b1;
      bus_addr = B + 0; settle();
      chk(bus_rdata, 16'h1234, "R1 read icand");
      chk(rd_sel, 4'b0001, "R1 rd_sel icand");
      step(); bus_addr = B + 1; settle();
      chk(bus_rdata, 16'hBEEF, "R1 read acc");
      chk(rd_sel, 4'b0010, "R1 rd_sel acc");
      step(); bus_addr = B + 2; settle();
      chk(bus_rdata, 16'h0F0F, "R1 read ier");
      chk(rd_sel, 4'b0100, "R1 rd_sel ier");
      step(); idle_bus();
   endtask

   task automatic t_writes_idle();
      bus_wr = 1'b1;
      bus_wdata = 16'hA5A5; bus_addr = B + 0; settle();
      chk({ld_icand, ld_acc, ld_ier}, 3'b100, "R2 load icand");
      chk(ld_data, 16'hA5A5, "R2 ld_data");
      step(); bus_wdata = 16'h5A5A; bus_addr = B + 1; settle();
      chk({ld_icand, ld_acc, ld_ier}, 3'b010, "R2 load acc");
      step(); bus_addr = B + 2; settle();
      chk({ld_icand, ld_acc, ld_ier}, 3'b001, "R2 load ier");
      chk(ld_data, 16'h5A5A, "R2 ld_data second");
      step(); idle_bus();
   endtask

   task automatic t_start();
      bus_wr = 1'b1; bus_addr = B + 3; bus_wdata = 16'hFFFF;
      settle();
      chk(start_pulse, 0, "R3 no pulse in write cycle");
      chk({ld_icand, ld_acc, ld_ier}, 0, "R3 no load on ctrl write");
      step(); idle_bus(); settle();
      chk(start_pulse, 1, "R3 pulse after write");
      step(); settle();
      chk(start_pulse, 0, "R3 pulse one cycle");
      bus_wr = 1'b1; bus_addr = B + 3; bus_wdata = 16'h0000;
      step(); settle();
      chk(start_pulse, 1, "R3 held write first pulse");
      step(); settle();
      chk(start_pulse, 0, "R3 held write no repeat");
      step(); idle_bus(); settle();
      chk(start_pulse, 0, "R3 after held write");
      step();
   endtask

   task automatic t_status();
      bus_rd = 1'b1; bus_addr = B + 3; core_run = 1'b0; settle();
      chk(bus_rdata, 16'h0000, "R4 status idle");
      step(); core_run = 1'b1; settle();
      chk(bus_rdata, 16'h0001, "R4 status busy");
      chk(bus_wait, 0, "R4 status no wait");
      chk(rd_sel, 4'b1000, "R4 rd_sel ctrl");
      step(); core_run = 1'b0; idle_bus();
   endtask

   task automatic t_hold(input logic [AW-1:0] a, input logic [DW-1:0] v, input string tag);
      core_run = 1'b1; bus_rd = 1'b1; bus_addr = a;
      for (int i = 0; i < 3; i++) begin
         settle();
         chk(bus_wait, 1, {tag, " wait while busy"});
         chk(bus_rdata, 0, {tag, " zero data while busy"});
         step();
      end
      core_run = 1'b0; settle();
      chk(bus_wait, 0, {tag, " wait released"});
      chk(bus_rdata, v, {tag, " data on release"});
      step(); idle_bus();
   endtask

   task automatic t_icand_busy();
      core_run = 1'b1; bus_rd = 1'b1; bus_addr = B + 0; settle();
      chk(bus_wait, 0, "R6 icand not held");
      chk(bus_rdata, 16'h1234, "R6 icand data while busy");
      step(); core_run = 1'b0; idle_bus();
   endtask

   task automatic t_busy_writes();
      core_run = 1'b1; bus_wr = 1'b1;
      for (int i = 0; i < 3; i++) begin
         bus_addr = B + AW'(i); settle();
         chk({ld_icand, ld_acc, ld_ier}, 0, "R7 load ignored busy");
         step();
      end
      bus_addr = B + 3; step(); idle_bus(); settle();
      chk(start_pulse, 0, "R7 start ignored busy");
      step(); core_run = 1'b0;
   endtask

   task automatic t_outside();
      bus_wr = 1'b1; bus_rd = 1'b1; core_run = 1'b1;
      bus_addr = B + 4; settle();
      chk({ld_icand, ld_acc, ld_ier, bus_wait}, 0, "R8 above window strobes");
      chk(rd_sel, 0, "R8 above window rd_sel");
      chk(bus_rdata, 0, "R8 above window rdata");
      step(); core_run = 1'b0; bus_addr = B - 1; settle();
      chk({ld_icand, ld_acc, ld_ier, bus_wait}, 0, "R8 below window strobes");
      chk(bus_rdata, 0, "R8 below window rdata");
      step(); idle_bus(); settle();
      chk(start_pulse, 0, "R8 no start outside");
      step();
   endtask

   initial begin : watchdog
      #1000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1;
      t_reset();
      t_reads_idle();
      t_writes_idle();
      t_start();
      t_status();
      t_hold(B + 1, 16'hBEEF, "R5 acc");
      t_hold(B + 2, 16'h0F0F, "R6 ier");
      t_icand_busy();
      t_busy_writes();
      t_outside();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule